// File: doc/BRIEF.md
# Variable Byte Blend Execution Unit

This unit merges two 256-bit vector operands one byte at a time. Each result byte comes from one of the two sources. The choice is set by the top bit of the matching byte in a mask vector. The unit holds its own 16-entry by 256-bit vector register file. The file has three read ports, for the first source, the second source and the mask. The second source can also be taken from a memory data input instead of a register.

Three operation forms are supported:

| Form | Mask register | First source | Destination bits 255:128 |
|---|---|---|---|
| Legacy | always register 0 | the destination register itself | kept |
| Narrow non-destructive | picked by the immediate | a separate register | written as zero |
| Wide non-destructive | picked by the immediate | a separate register | blended, all 32 lanes |

An operation is accepted on a clock edge while `op_valid` is high. Its result, the write enable and the fault flag appear in the registered outputs after that same edge. The register write happens on that same edge.

A fill port is the only way to put data into the register file other than a blend result. It is accepted only when no operation is issued in that cycle. A legacy opcode issued together with the extended-prefix indicator is an invalid-opcode fault. It writes nothing.

Top module: `vblend_unit`

## Requirements
- R1: For each byte lane i, the result byte is second-source byte i when bit 7 of mask byte i is 1, and first-source byte i when that bit is 0.
- R2: The legacy form (`legacy_op`=1, `ext_prefix`=0) uses register 0 as the mask. It uses register `dst_idx` as the first source, and writes the result back to `dst_idx`. `src1_idx` and `imm` have no effect in this form.
- R3: The legacy form blends lanes 0 to 15 only. Destination bits 255:128 keep their previous contents.
- R4: The narrow non-destructive form (`legacy_op`=0, `wide`=0) blends lanes 0 to 15 and writes destination bits 255:128 as zero.
- R5: The wide non-destructive form (`legacy_op`=0, `wide`=1) blends all 32 lanes.
- R6: In both non-destructive forms, the mask register index is `imm[7:4]`. `imm[3:0]` has no effect.
- R7: When `mode32` is 1, `imm[7]` is treated as 0 by the non-destructive forms, so only registers 0 to 7 can serve as the mask.
- R8: When `legacy_op`=1 and `ext_prefix`=1, the unit writes no register, and the next outputs show `out_fault`=1, `out_we`=0 and `out_result`=0.
- R9: When `mem_sel`=1, the second source is `mem_data` instead of register `src2_idx`. The 128-bit forms use only `mem_data[127:0]`.
- R10: An operation accepted at an edge gives `out_valid`=1 with its result, `out_we` and `out_widx` right after that edge. An edge with `op_valid`=0 gives `out_valid`=0 and `out_we`=0.
- R11: A synchronous reset clears every register to zero and clears all registered outputs to zero.
- R12: With `op_valid`=0 and `fill_en`=1, register `fill_idx` takes `fill_data` at the edge. `fill_en` has no effect in a cycle where `op_valid`=1.
- R13: `dbg_data` always shows the current contents of register `dbg_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Issue an operation at this edge |
| legacy_op | input | 1 | Legacy-form opcode |
| ext_prefix | input | 1 | Extended-prefix indicator |
| wide | input | 1 | Non-destructive forms: 1 selects 256-bit, 0 selects 128-bit |
| mode32 | input | 1 | 32-bit mode: drops imm[7] from the mask index |
| dst_idx | input | 4 | Destination register (also the first source in the legacy form) |
| src1_idx | input | 4 | First-source register for the non-destructive forms |
| src2_idx | input | 4 | Second-source register |
| imm | input | 8 | Immediate byte; bits 7:4 give the mask register |
| mem_sel | input | 1 | Take the second source from mem_data |
| mem_data | input | 256 | Memory operand |
| fill_en | input | 1 | Register fill request |
| fill_idx | input | 4 | Register to fill |
| fill_data | input | 256 | Fill value |
| dbg_idx | input | 4 | Register to observe |
| dbg_data | output | 256 | Contents of register dbg_idx |
| out_valid | output | 1 | An operation completed at the last edge |
| out_fault | output | 1 | Invalid-opcode fault |
| out_we | output | 1 | The destination register was written |
| out_widx | output | 4 | Destination index of the completed operation |
| out_result | output | 256 | Result vector |

## Verification
The hardest conditions to reach from the ports are the ones that depend on what is already in the mask register. An empty register file masks every lane to the first source, so the blend can never be seen until registers hold chosen patterns. The stimulus first fills the file through the fill port, with alternating 0x80/0x7F mask bytes and with random values. It then sweeps all three forms against random immediates, with mode32 and with memory operands.

Reaching the upper-half behaviour needs a destination that already holds non-zero upper bits before each narrow operation. A fill issued in the same cycle as an operation is checked afterwards through the debug port.

// File: rtl/vblend_unit.sv
module vblend_unit #(
  parameter int NREG = 16,
  parameter int VW   = 256
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     op_valid,
  input  logic                     legacy_op,
  input  logic                     ext_prefix,
  input  logic                     wide,
  input  logic                     mode32,
  input  logic [$clog2(NREG)-1:0]  dst_idx,
  input  logic [$clog2(NREG)-1:0]  src1_idx,
  input  logic [$clog2(NREG)-1:0]  src2_idx,
  input  logic [7:0]               imm,
  input  logic                     mem_sel,
  input  logic [VW-1:0]            mem_data,
  input  logic                     fill_en,
  input  logic [$clog2(NREG)-1:0]  fill_idx,
  input  logic [VW-1:0]            fill_data,
  input  logic [$clog2(NREG)-1:0]  dbg_idx,
  output logic [VW-1:0]            dbg_data,
  output logic                     out_valid,
  output logic                     out_fault,
  output logic                     out_we,
  output logic [$clog2(NREG)-1:0]  out_widx,
  output logic [VW-1:0]            out_result
);
  localparam int IW  = $clog2(NREG);
  localparam int LW  = VW / 2;
  localparam int NB  = VW / 8;

  logic [VW-1:0] rf [NREG];
  logic [IW-1:0] a_idx, m_idx;
  logic [3:0]    imm_sel;
  logic [VW-1:0] rd_a, rd_b, rd_m, src_b, blended, res;
  logic          bad_op;

  assign imm_sel = {imm[7] & ~mode32, imm[6:4]};
  assign a_idx   = legacy_op ? dst_idx : src1_idx;
  assign m_idx   = legacy_op ? '0 : IW'(imm_sel);
  assign rd_a    = rf[a_idx];
  assign rd_b    = rf[src2_idx];
  assign rd_m    = rf[m_idx];
  assign src_b   = mem_sel ? mem_data : rd_b;
  assign bad_op  = legacy_op & ext_prefix;
  assign dbg_data = rf[dbg_idx];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign blended[g*8 +: 8] = rd_m[g*8 + 7] ? src_b[g*8 +: 8] : rd_a[g*8 +: 8];
  end

  always_comb begin
    if (bad_op)         res = '0;
    else if (legacy_op) res = {rd_a[VW-1:LW], blended[LW-1:0]};
    else if (!wide)     res = {{LW{1'b0}}, blended[LW-1:0]};
    else                res = blended;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      out_valid  <= 1'b0;
      out_fault  <= 1'b0;
      out_we     <= 1'b0;
      out_widx   <= '0;
      out_result <= '0;
    end else begin
      out_valid  <= op_valid;
      out_fault  <= op_valid & bad_op;
      out_we     <= op_valid & ~bad_op;
      out_widx   <= op_valid ? dst_idx : '0;
      out_result <= op_valid ? res : '0;
      if (op_valid) begin
        if (!bad_op) rf[dst_idx] <= res;
      end else if (fill_en) begin
        rf[fill_idx] <= fill_data;
      end
    end
  end

  p_fault_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    out_fault |-> (!out_we && out_result == '0));

  p_legacy_upper_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && legacy_op && !ext_prefix) |=> (out_result[VW-1:LW] == $past(rd_a[VW-1:LW])));

  p_narrow_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !legacy_op && !wide) |=> (out_result[VW-1:LW] == '0));

  p_issue_gives_valid_r10: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> out_valid);

  p_idle_no_write_r10: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!out_valid && !out_we));

  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !bad_op) |=> (rf[$past(dst_idx)] == out_result));

  p_mode32_low_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !legacy_op && mode32) |-> (m_idx < IW'(8)));
endmodule

// File: tb/vblend_unit_test.sv
module vblend_unit_test;
  logic clk = 0, rst = 1;
  logic op_valid = 0, legacy_op = 0, ext_prefix = 0, wide = 0, mode32 = 0, mem_sel = 0, fill_en = 0;
  logic [3:0] dst_idx = 0, src1_idx = 0, src2_idx = 0, fill_idx = 0, dbg_idx = 0;
  logic [7:0] imm = 0;
  logic [255:0] mem_data = 0, fill_data = 0;
  logic [255:0] dbg_data, out_result;
  logic out_valid, out_fault, out_we;
  logic [3:0] out_widx;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [255:0] m_rf [16];

  always #10 clk = ~clk;

  vblend_unit uut (.clk(clk), .rst(rst), .op_valid(op_valid), .legacy_op(legacy_op),
    .ext_prefix(ext_prefix), .wide(wide), .mode32(mode32), .dst_idx(dst_idx),
    .src1_idx(src1_idx), .src2_idx(src2_idx), .imm(imm), .mem_sel(mem_sel),
    .mem_data(mem_data), .fill_en(fill_en), .fill_idx(fill_idx), .fill_data(fill_data),
    .dbg_idx(dbg_idx), .dbg_data(dbg_data), .out_valid(out_valid), .out_fault(out_fault),
    .out_we(out_we), .out_widx(out_widx), .out_result(out_result));

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check_rf(input string tag);
    for (int r = 0; r < 16; r++) begin
      dbg_idx = 4'(r);
      #1;
      chk(dbg_data === m_rf[r], tag, dbg_data, m_rf[r]);
    end
  endtask

  task automatic fill(input int idx, input logic [255:0] val);
    @(negedge clk);
    fill_en = 1; fill_idx = 4'(idx); fill_data = val;
    @(negedge clk);
    fill_en = 0;
    m_rf[idx] = val;
  endtask

  task automatic do_op(input bit leg, input bit pre, input bit wd, input int d, input int s1,
                       input int s2, input logic [7:0] im, input bit m32, input bit msel,
                       input logic [255:0] md, input string tag);
    logic [255:0] a, b, m, exp;
    int mi;
    bit flt;
    @(negedge clk);
    op_valid = 1; legacy_op = leg; ext_prefix = pre; wide = wd; dst_idx = 4'(d);
    src1_idx = 4'(s1); src2_idx = 4'(s2); imm = im; mode32 = m32; mem_sel = msel; mem_data = md;
    flt = leg && pre;
    mi = leg ? 0 : ((m32 ? 0 : im[7]) * 8 + im[6:4]);
    a = leg ? m_rf[d] : m_rf[s1];
    b = msel ? md : m_rf[s2];
    m = m_rf[mi];
    exp = 0;
    if (!flt) begin
      for (int i = 0; i < 32; i++) begin
        logic [7:0] byt;
        byt = m[i*8+7] ? b[i*8 +: 8] : a[i*8 +: 8];
        if (i < 16 || (!leg && wd)) exp[i*8 +: 8] = byt;
        else if (leg) exp[i*8 +: 8] = a[i*8 +: 8];
      end
      m_rf[d] = exp;
    end
    @(negedge clk);
    op_valid = 0;
    chk(out_valid === 1'b1, {tag, " R10 valid"}, 256'(out_valid), 256'(1));
    chk(out_fault === flt, {tag, " R8 fault"}, 256'(out_fault), 256'(flt));
    chk(out_we === !flt, {tag, " R8/R10 we"}, 256'(out_we), 256'(!flt));
    if (!flt) chk(out_widx === 4'(d), {tag, " R10 widx"}, 256'(out_widx), 256'(d));
    chk(out_result === exp, {tag, " R1 result"}, out_result, exp);
    dbg_idx = 4'(d);
    #1;
    chk(dbg_data === m_rf[d], {tag, " R13 dest"}, dbg_data, m_rf[d]);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    for (int r = 0; r < 16; r++) m_rf[r] = '0;
    chk(out_valid === 0 && out_fault === 0 && out_we === 0 && out_widx === 0, "R11 flags",
        {out_valid, out_fault, out_we, out_widx}, 0);
    chk(out_result === '0, "R11 result", out_result, 0);
    check_rf("R11 regfile");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [255:0] alt, hi;
    for (int r = 0; r < 16; r++) m_rf[r] = '0;
    do_reset();

    for (int i = 0; i < 32; i++) alt[i*8 +: 8] = (i % 2) ? 8'h7F : 8'h80;
    fill(0, alt);
    for (int r = 1; r < 16; r++) fill(r, rnd256());
    check_rf("R12 fill");

    @(negedge clk);
    op_valid = 1; legacy_op = 0; ext_prefix = 1; wide = 1; dst_idx = 4'd3; src1_idx = 4'd4;
    src2_idx = 4'd5; imm = 8'h20; mode32 = 0; mem_sel = 0;
    fill_en = 1; fill_idx = 4'd9; fill_data = ~m_rf[9];
    begin
      logic [255:0] e;
      for (int i = 0; i < 32; i++)
        e[i*8 +: 8] = m_rf[2][i*8+7] ? m_rf[5][i*8 +: 8] : m_rf[4][i*8 +: 8];
      m_rf[3] = e;
    end
    @(negedge clk);
    op_valid = 0; fill_en = 0;
    dbg_idx = 4'd9; #1;
    chk(dbg_data === m_rf[9], "R12 fill blocked during op", dbg_data, m_rf[9]);

    @(negedge clk);
    chk(out_valid === 0 && out_we === 0, "R10 idle", {out_valid, out_we}, 0);

    do_op(1, 0, 0, 6, 11, 7, 8'hF5, 0, 0, 0, "legacy R2 R3");
    do_op(1, 0, 1, 8, 2, 10, 8'h3C, 1, 0, 0, "legacy R2 R3 wide-ignored");
    do_op(0, 1, 0, 12, 0, 13, 8'h00, 0, 0, 0, "narrow R4 mask0");
    do_op(0, 1, 1, 14, 0, 15, 8'h00, 0, 0, 0, "wide R5 mask0");
    do_op(0, 1, 1, 1, 2, 3, 8'h5A, 0, 0, 0, "wide R6 low nibble");
    do_op(0, 1, 1, 1, 2, 3, 8'h55, 0, 0, 0, "wide R6 low nibble alt");
    do_op(0, 1, 1, 4, 5, 6, 8'hB0, 1, 0, 0, "wide R7 mode32");
    do_op(0, 1, 0, 4, 5, 6, 8'hE7, 1, 0, 0, "narrow R7 mode32");
    do_op(0, 1, 1, 4, 5, 6, 8'hB0, 0, 0, 0, "wide R7 mode32 off");
    do_op(1, 1, 0, 7, 1, 2, 8'h00, 0, 0, 0, "R8 fault");
    do_op(0, 1, 1, 9, 10, 11, 8'h00, 0, 1, rnd256(), "wide R9 mem");
    do_op(0, 1, 0, 9, 10, 11, 8'h00, 0, 1, rnd256(), "narrow R9 mem");
    do_op(1, 0, 0, 10, 3, 11, 8'h00, 0, 1, rnd256(), "legacy R9 mem");

    for (int n = 0; n < 300; n++) begin
      if (n % 17 == 0) fill($urandom_range(0, 15), rnd256());
      do_op($urandom_range(0, 3) == 0, $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
            8'($urandom), $urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0, rnd256(),
            "sweep R1");
    end
    check_rf("R2 regfile after sweep");

    do_reset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule